// File: doc/BRIEF.md
# ATM Cell Header Router and Translator

This block steers ATM cells arriving as a byte stream, one direction of traffic per instance. From each cell's header it reads the 12-bit path identifier (VPI), the 16-bit channel identifier (VCI) and the payload type (PTI). It looks these up in a connection table written by a management CPU, each entry configured on its own. A matched cell leaves with a rewritten header and a 2-bit destination tag. Cells for a broadcast path go to the CPU. Operation-and-maintenance cells on configured connections also go to the CPU. Cells that fall outside the accepted path range, or that hit no entry, are flagged for discard and counted.

Every input byte comes out exactly four cycles later with the same framing. The routing decision is taken on the fourth header byte and applied to the whole cell, so there is no stall and no gap. Queueing, multiplexing and the physical cell-bus handshake belong to neighbouring blocks. Those blocks act on the tags: they forward a cell, hand it to the CPU or drop it. They also recompute the header check byte of rewritten cells. One instance is built per direction. Setting `RANGE_FILTER` to 1 compares the upper path bits with a programmable register. Setting it to 0 requires those bits to be zero.

Top module: `atm_vc_xlate`

## Requirements
- R1: Each input byte reappears on the output exactly 4 cycles after it is accepted, with the same valid and start-of-cell marking. Bytes from index 4 of a cell onward, including the header check byte, are unchanged.
- R2: The header layout is fixed. Byte 0 carries VPI[11:4]. Byte 1 carries VPI[3:0] and VCI[15:12]. Byte 2 carries VCI[11:4]. Byte 3 carries VCI[3:0], PTI[2:0] and CLP. A channel entry (valid, channel flag set) matches when its stored VPI[3:0] and VCI[7:0] equal the cell's and VCI[15:8] is zero. The cell then leaves with `out_cpu`=0, `out_drop`=0 and the entry's port on `out_port`. VPI and VCI are replaced by the entry's new values, and PTI and CLP are kept.
- R3: A path entry (valid, channel flag clear) matches on VPI[3:0] alone. It replaces the VPI, keeps the VCI, and tags the cell with its port.
- R4: When a channel entry and a path entry both match, the channel entry is used. Among matching entries of the same kind, the lowest index is used.
- R5: With the range filter on, a cell whose VPI[11:4] differs from the range register is flagged `out_drop`=1, unless R6 applies.
- R6: When broadcast is enabled and the cell's full 12-bit VPI equals the broadcast register, the cell is flagged `out_cpu`=1. This holds whatever the range filter and the table say.
- R7: A cell with VCI 3 (segment) or VCI 4 (end-to-end) is flagged `out_cpu`=1 when any valid entry has the same VPI[3:0].
- R8: A cell that hits a channel entry and carries PTI 3'b100 is flagged `out_cpu`=1. On a path entry, such a cell is forwarded as in R3.
- R9: A cell that hits no valid entry is flagged `out_drop`=1. CPU-bound and dropped cells keep their original header bytes, and `out_port` is 0 for them.
- R10: `drop_count` rises by exactly one for each dropped cell. The step is visible in the cycle that cell's first byte is on the output.
- R11: After reset, `out_valid` is 0, `drop_count` is 0, the range register is 0, broadcast is disabled and every table entry is invalid.
- R12: A table write replaces the whole entry at the given index. Writing it with valid=0 removes it from all matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_sop | input | 1 | Input byte is byte 0 of a cell |
| in_data | input | 8 | Input cell byte |
| cfg_tbl_we | input | 1 | Write one table entry |
| cfg_tbl_idx | input | IDX_W | Entry index to write |
| cfg_tbl_valid | input | 1 | Entry in use |
| cfg_tbl_vc | input | 1 | 1: channel entry, 0: path entry |
| cfg_tbl_port | input | 2 | Destination tag for the entry |
| cfg_tbl_vpi_lo | input | 4 | VPI[3:0] to match |
| cfg_tbl_vci_lo | input | 8 | VCI[7:0] to match (channel entries) |
| cfg_tbl_new_vpi | input | 12 | Replacement VPI |
| cfg_tbl_new_vci | input | 16 | Replacement VCI (channel entries) |
| cfg_range_we | input | 1 | Write the range register |
| cfg_range | input | 8 | Accepted VPI[11:4] |
| cfg_bcast_we | input | 1 | Write the broadcast register |
| cfg_bcast_en | input | 1 | Broadcast enable |
| cfg_bcast_vpi | input | 12 | Broadcast VPI |
| out_valid | output | 1 | Output byte present |
| out_sop | output | 1 | Output byte is byte 0 of a cell |
| out_data | output | 8 | Output cell byte, header translated |
| out_port | output | 2 | Destination tag of a forwarded cell |
| out_cpu | output | 1 | Cell goes to the CPU |
| out_drop | output | 1 | Cell is to be discarded |
| drop_count | output | CNT_W | Number of discarded cells |

## Verification
The checker assumes three things about the inputs. The five header bytes of a cell come on consecutive cycles. A cell is at least five bytes long before the next start-of-cell. The range and broadcast registers do not change while a cell is inside the block. The bench keeps within these rules. It drives every cell as six back-to-back bytes followed by idle cycles that flush it out. It writes configuration only between cells, when nothing is in flight. Its sweep covers path ranges on both sides of the filter, every low VPI value in use, VCIs on and off the table, including the maintenance values and one with upper bits set, and both payload types of interest.

// File: rtl/atm_vcx_pkg.sv
package atm_vcx_pkg;

   // header bytes that carry VPI/VCI/PTI; the routing decision is taken on the last one
   localparam int HDR_BYTES = 4;

   localparam logic [15:0] VCI_F4_SEG = 16'd3;
   localparam logic [15:0] VCI_F4_E2E = 16'd4;
   localparam logic [2:0]  PTI_F5_SEG = 3'b100;

   typedef enum logic [1:0] {
      ACT_FWD  = 2'd0,
      ACT_CPU  = 2'd1,
      ACT_DROP = 2'd2
   } act_e;

   typedef struct packed {
      logic        valid;
      logic        vc;
      logic [1:0]  port;
      logic [3:0]  vpi_lo;
      logic [7:0]  vci_lo;
      logic [11:0] new_vpi;
      logic [15:0] new_vci;
   } conn_t;

   typedef struct packed {
      act_e        act;
      logic [1:0]  port;
      logic [11:0] vpi;
      logic [15:0] vci;
   } dec_t;

endpackage

// File: rtl/atm_vcx_table.sv
module atm_vcx_table
   import atm_vcx_pkg::*;
#(
   parameter  int ENTRIES = 128,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  conn_t            wr_ent,
   input  logic [3:0]       key_vpi_lo,
   input  logic [15:0]      key_vci,
   output logic             vp_hit,
   output logic [1:0]       vp_port,
   output logic [11:0]      vp_vpi,
   output logic             vc_hit,
   output logic [1:0]       vc_port,
   output logic [11:0]      vc_vpi,
   output logic [15:0]      vc_vci,
   output logic             vpi_known
);

   conn_t              tbl_q [ENTRIES];
   logic [ENTRIES-1:0] vp_m;
   logic [ENTRIES-1:0] vc_m;
   logic [ENTRIES-1:0] any_m;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
      end else if (wr_en) begin
         tbl_q[wr_idx] <= wr_ent;
      end
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_match
      logic path_eq;
      assign path_eq  = tbl_q[g].valid && (tbl_q[g].vpi_lo == key_vpi_lo);
      assign any_m[g] = path_eq;
      assign vp_m[g]  = path_eq && !tbl_q[g].vc;
      assign vc_m[g]  = path_eq && tbl_q[g].vc &&
                        (tbl_q[g].vci_lo == key_vci[7:0]) && (key_vci[15:8] == 8'h00);
   end

   // lowest index wins: scan downward so the last assignment is the lowest hit
   always_comb begin
      vp_port = '0;
      vp_vpi  = '0;
      vc_port = '0;
      vc_vpi  = '0;
      vc_vci  = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (vp_m[i]) begin
            vp_port = tbl_q[i].port;
            vp_vpi  = tbl_q[i].new_vpi;
         end
         if (vc_m[i]) begin
            vc_port = tbl_q[i].port;
            vc_vpi  = tbl_q[i].new_vpi;
            vc_vci  = tbl_q[i].new_vci;
         end
      end
   end

   assign vp_hit    = |vp_m;
   assign vc_hit    = |vc_m;
   assign vpi_known = |any_m;

endmodule

// File: rtl/atm_vcx_delay.sv
module atm_vcx_delay #(
   parameter int STAGES = 4,
   parameter int W      = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         in_sop,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic         out_sop,
   output logic [W-1:0] out_data
);

   logic [STAGES-1:0] v_q;
   logic [STAGES-1:0] s_q;
   logic [W-1:0]      d_q [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic         v_in;
      logic         s_in;
      logic [W-1:0] d_in;
      if (g == 0) begin : g_head
         assign v_in = in_valid;
         assign s_in = in_sop;
         assign d_in = in_data;
      end else begin : g_body
         assign v_in = v_q[g-1];
         assign s_in = s_q[g-1];
         assign d_in = d_q[g-1];
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q[g] <= 1'b0;
            s_q[g] <= 1'b0;
            d_q[g] <= '0;
         end else begin
            v_q[g] <= v_in;
            s_q[g] <= s_in && v_in;
            d_q[g] <= d_in;
         end
      end
   end

   assign out_valid = v_q[STAGES-1];
   assign out_sop   = s_q[STAGES-1];
   assign out_data  = d_q[STAGES-1];

endmodule

// File: rtl/atm_vc_xlate.sv
module atm_vc_xlate
   import atm_vcx_pkg::*;
#(
   parameter  int ENTRIES      = 128,
   parameter  bit RANGE_FILTER = 1'b1,
   parameter  int CNT_W        = 16,
   localparam int IDX_W        = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic [7:0]       in_data,
   input  logic             cfg_tbl_we,
   input  logic [IDX_W-1:0] cfg_tbl_idx,
   input  logic             cfg_tbl_valid,
   input  logic             cfg_tbl_vc,
   input  logic [1:0]       cfg_tbl_port,
   input  logic [3:0]       cfg_tbl_vpi_lo,
   input  logic [7:0]       cfg_tbl_vci_lo,
   input  logic [11:0]      cfg_tbl_new_vpi,
   input  logic [15:0]      cfg_tbl_new_vci,
   input  logic             cfg_range_we,
   input  logic [7:0]       cfg_range,
   input  logic             cfg_bcast_we,
   input  logic             cfg_bcast_en,
   input  logic [11:0]      cfg_bcast_vpi,
   output logic             out_valid,
   output logic             out_sop,
   output logic [7:0]       out_data,
   output logic [1:0]       out_port,
   output logic             out_cpu,
   output logic             out_drop,
   output logic [CNT_W-1:0] drop_count
);

   localparam int          DLY      = HDR_BYTES;
   localparam logic [2:0]  POS_LAST = 3'(HDR_BYTES - 1);
   localparam logic [2:0]  POS_SAT  = 3'(HDR_BYTES);

   if (ENTRIES < 2 || ENTRIES > 4096) begin : g_bad_entries
      $error("atm_vc_xlate: ENTRIES must lie in 2..4096");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("atm_vc_xlate: CNT_W must be positive");
   end

   // ---------------- input framing and header capture ----------------
   logic [2:0]  in_pos_q, in_idx;
   logic [7:0]  b0_q, b1_q, b2_q;
   logic        dec_take;

   assign in_idx   = in_sop ? 3'd0 : in_pos_q;
   assign dec_take = in_valid && (in_idx == POS_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_pos_q <= 3'd0;
         b0_q     <= '0;
         b1_q     <= '0;
         b2_q     <= '0;
      end else if (in_valid) begin
         in_pos_q <= (in_idx == POS_SAT) ? POS_SAT : in_idx + 3'd1;
         case (in_idx)
            3'd0:    b0_q <= in_data;
            3'd1:    b1_q <= in_data;
            3'd2:    b2_q <= in_data;
            default: ;
         endcase
      end
   end

   logic [11:0] cur_vpi;
   logic [15:0] cur_vci;
   logic [2:0]  cur_pti;
   assign cur_vpi = {b0_q, b1_q[7:4]};
   assign cur_vci = {b1_q[3:0], b2_q, in_data[7:4]};
   assign cur_pti = in_data[3:1];

   // ---------------- configuration registers ----------------
   logic        bcast_en_q;
   logic [11:0] bcast_vpi_q;
   logic        in_range;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bcast_en_q  <= 1'b0;
         bcast_vpi_q <= '0;
      end else if (cfg_bcast_we) begin
         bcast_en_q  <= cfg_bcast_en;
         bcast_vpi_q <= cfg_bcast_vpi;
      end
   end

   if (RANGE_FILTER) begin : g_range
      logic [7:0] rng_q;
      always_ff @(posedge clk) begin
         if (!rst_n)            rng_q <= '0;
         else if (cfg_range_we) rng_q <= cfg_range;
      end
      assign in_range = (cur_vpi[11:4] == rng_q);
   end else begin : g_fixed
      logic [8:0] unused_rng;
      assign unused_rng = {cfg_range_we, cfg_range};
      assign in_range   = (cur_vpi[11:4] == 8'h00);
   end

   // ---------------- connection table ----------------
   conn_t       wr_ent;
   logic        vp_hit, vc_hit, vpi_known;
   logic [1:0]  vp_port, vc_port;
   logic [11:0] vp_vpi, vc_vpi;
   logic [15:0] vc_vci;

   assign wr_ent = '{valid:   cfg_tbl_valid,  vc:      cfg_tbl_vc,
                     port:    cfg_tbl_port,   vpi_lo:  cfg_tbl_vpi_lo,
                     vci_lo:  cfg_tbl_vci_lo, new_vpi: cfg_tbl_new_vpi,
                     new_vci: cfg_tbl_new_vci};

   atm_vcx_table #(.ENTRIES(ENTRIES)) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_tbl_we),
      .wr_idx     (cfg_tbl_idx),
      .wr_ent     (wr_ent),
      .key_vpi_lo (cur_vpi[3:0]),
      .key_vci    (cur_vci),
      .vp_hit     (vp_hit),
      .vp_port    (vp_port),
      .vp_vpi     (vp_vpi),
      .vc_hit     (vc_hit),
      .vc_port    (vc_port),
      .vc_vpi     (vc_vpi),
      .vc_vci     (vc_vci),
      .vpi_known  (vpi_known)
   );

   // ---------------- routing decision ----------------
   dec_t dec_d, dec_q;
   logic bcast_hit, is_f4;

   assign bcast_hit = bcast_en_q && (cur_vpi == bcast_vpi_q);
   assign is_f4     = (cur_vci == VCI_F4_SEG) || (cur_vci == VCI_F4_E2E);

   always_comb begin
      dec_d = '{act: ACT_DROP, port: 2'd0, vpi: cur_vpi, vci: cur_vci};
      if (bcast_hit) begin
         dec_d.act = ACT_CPU;
      end else if (!in_range) begin
         dec_d.act = ACT_DROP;
      end else if (is_f4 && vpi_known) begin
         dec_d.act = ACT_CPU;
      end else if (vc_hit) begin
         if (cur_pti == PTI_F5_SEG) begin
            dec_d.act = ACT_CPU;
         end else begin
            dec_d.act  = ACT_FWD;
            dec_d.port = vc_port;
            dec_d.vpi  = vc_vpi;
            dec_d.vci  = vc_vci;
         end
      end else if (vp_hit) begin
         dec_d.act  = ACT_FWD;
         dec_d.port = vp_port;
         dec_d.vpi  = vp_vpi;
      end
   end

   logic [CNT_W-1:0] drop_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_q  <= '{act: ACT_DROP, port: 2'd0, vpi: 12'd0, vci: 16'd0};
         drop_q <= '0;
      end else if (dec_take) begin
         dec_q <= dec_d;
         if (dec_d.act == ACT_DROP) drop_q <= drop_q + 1'b1;
      end
   end

   // ---------------- delayed stream and header rewrite ----------------
   logic       d_valid, d_sop;
   logic [7:0] d_data;
   logic [2:0] out_pos_q, out_idx;

   atm_vcx_delay #(.STAGES(DLY), .W(8)) u_delay (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sop    (in_sop),
      .in_data   (in_data),
      .out_valid (d_valid),
      .out_sop   (d_sop),
      .out_data  (d_data)
   );

   assign out_idx = d_sop ? 3'd0 : out_pos_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       out_pos_q <= 3'd0;
      else if (d_valid) out_pos_q <= (out_idx == POS_SAT) ? POS_SAT : out_idx + 3'd1;
   end

   always_comb begin
      case (out_idx)
         3'd0:    out_data = dec_q.vpi[11:4];
         3'd1:    out_data = {dec_q.vpi[3:0], dec_q.vci[15:12]};
         3'd2:    out_data = dec_q.vci[11:4];
         3'd3:    out_data = {dec_q.vci[3:0], d_data[3:0]};
         default: out_data = d_data;
      endcase
   end

   assign out_valid  = d_valid;
   assign out_sop    = d_sop;
   assign out_port   = (d_valid && dec_q.act == ACT_FWD) ? dec_q.port : 2'd0;
   assign out_cpu    = d_valid && (dec_q.act == ACT_CPU);
   assign out_drop   = d_valid && (dec_q.act == ACT_DROP);
   assign drop_count = drop_q;

endmodule

// File: rtl/atm_vc_xlate_chk.sv
module atm_vc_xlate_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_sop,
   input logic [7:0]       in_data,
   input logic             out_valid,
   input logic             out_sop,
   input logic [7:0]       out_data,
   input logic             out_cpu,
   input logic             out_drop,
   input logic [CNT_W-1:0] drop_count,
   input logic             bcast_en,
   input logic [11:0]      bcast_vpi
);

   logic [2:0] cyc_q;
   logic [3:0] v_q, s_q;
   logic [7:0] d_q [4];
   logic [2:0] opos_q, oidx;

   assign oidx = out_sop ? 3'd0 : opos_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc_q  <= 3'd0;
         v_q    <= '0;
         s_q    <= '0;
         opos_q <= 3'd0;
         for (int i = 0; i < 4; i++) d_q[i] <= '0;
      end else begin
         if (cyc_q != 3'd4) cyc_q <= cyc_q + 3'd1;
         v_q    <= {v_q[2:0], in_valid};
         s_q    <= {s_q[2:0], in_sop && in_valid};
         d_q[0] <= in_data;
         for (int i = 1; i < 4; i++) d_q[i] <= d_q[i-1];
         if (out_valid) opos_q <= (oidx == 3'd4) ? 3'd4 : oidx + 3'd1;
      end
   end

   AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == 3'd4) |-> (out_valid == v_q[3]) && (out_sop == s_q[3])); // R1

   AST_PAYLOAD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == 3'd4 && out_valid && oidx == 3'd4) |-> (out_data == d_q[3])); // R1

   AST_UNROUTED_HDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == 3'd4 && out_valid && (out_cpu || out_drop)) |-> (out_data == d_q[3])); // R9

   AST_BCAST_TO_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == 3'd4 && out_valid && out_sop && bcast_en &&
       ({d_q[3], d_q[2][7:4]} == bcast_vpi)) |-> out_cpu); // R6

   AST_DROP_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q != 3'd0 && drop_count != $past(drop_count)) |->
      (out_valid && out_sop && out_drop && drop_count == $past(drop_count) + 1'b1)); // R10

endmodule

bind atm_vc_xlate atm_vc_xlate_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_sop     (in_sop),
   .in_data    (in_data),
   .out_valid  (out_valid),
   .out_sop    (out_sop),
   .out_data   (out_data),
   .out_cpu    (out_cpu),
   .out_drop   (out_drop),
   .drop_count (drop_count),
   .bcast_en   (bcast_en_q),
   .bcast_vpi  (bcast_vpi_q)
);

// File: tb/atm_vc_xlate_tb.sv
`timescale 1ns/1ps
module atm_vc_xlate_tb;

   localparam int N     = 8;
   localparam int IDX_W = $clog2(N);
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0, in_sop = 1'b0;
   logic [7:0]       in_data = '0;
   logic             cfg_tbl_we = 1'b0, cfg_tbl_valid = 1'b0, cfg_tbl_vc = 1'b0;
   logic [IDX_W-1:0] cfg_tbl_idx = '0;
   logic [1:0]       cfg_tbl_port = '0;
   logic [3:0]       cfg_tbl_vpi_lo = '0;
   logic [7:0]       cfg_tbl_vci_lo = '0;
   logic [11:0]      cfg_tbl_new_vpi = '0;
   logic [15:0]      cfg_tbl_new_vci = '0;
   logic             cfg_range_we = 1'b0, cfg_bcast_we = 1'b0, cfg_bcast_en = 1'b0;
   logic [7:0]       cfg_range = '0;
   logic [11:0]      cfg_bcast_vpi = '0;
   logic             out_valid, out_sop, out_cpu, out_drop;
   logic [7:0]       out_data;
   logic [1:0]       out_port;
   logic [CNT_W-1:0] drop_count;

   always #2.5 clk = ~clk;

   atm_vc_xlate #(.ENTRIES(N), .RANGE_FILTER(1'b1), .CNT_W(CNT_W)) u_dut (.*);

   int  n_run = 0, n_fail = 0;
   bit  finished = 1'b0;

   // bench-side view of the configuration
   bit          m_val [N];
   bit          m_vc  [N];
   logic [1:0]  m_port[N];
   logic [3:0]  m_lo  [N];
   logic [7:0]  m_clo [N];
   logic [11:0] m_nvpi[N];
   logic [15:0] m_nvci[N];
   logic [7:0]  m_rng = 8'h00;
   bit          m_ben = 1'b0;
   logic [11:0] m_bvpi = '0;
   int          exp_cnt = 0;
   string       phase = "";

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr_entry(input int idx, input bit v, input bit vc, input logic [1:0] port,
                           input logic [3:0] lo, input logic [7:0] clo,
                           input logic [11:0] nvpi, input logic [15:0] nvci);
      @(negedge clk);
      cfg_tbl_we = 1'b1; cfg_tbl_idx = IDX_W'(idx); cfg_tbl_valid = v; cfg_tbl_vc = vc;
      cfg_tbl_port = port; cfg_tbl_vpi_lo = lo; cfg_tbl_vci_lo = clo;
      cfg_tbl_new_vpi = nvpi; cfg_tbl_new_vci = nvci;
      m_val[idx] = v; m_vc[idx] = vc; m_port[idx] = port; m_lo[idx] = lo;
      m_clo[idx] = clo; m_nvpi[idx] = nvpi; m_nvci[idx] = nvci;
      @(negedge clk);
      cfg_tbl_we = 1'b0;
   endtask

   task automatic wr_regs(input logic [7:0] rng, input bit ben, input logic [11:0] bvpi);
      @(negedge clk);
      cfg_range_we = 1'b1; cfg_range = rng;
      cfg_bcast_we = 1'b1; cfg_bcast_en = ben; cfg_bcast_vpi = bvpi;
      m_rng = rng; m_ben = ben; m_bvpi = bvpi;
      @(negedge clk);
      cfg_range_we = 1'b0; cfg_bcast_we = 1'b0;
   endtask

   // act: 0 forward, 1 cpu, 2 drop
   task automatic model(input logic [11:0] vpi, input logic [15:0] vci, input logic [2:0] pti,
                        output int act, output logic [1:0] port,
                        output logic [11:0] ovpi, output logic [15:0] ovci, output string req);
      int  vp_i = -1, vc_i = -1;
      bit  known = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (m_val[i] && m_lo[i] == vpi[3:0]) begin
            known = 1'b1;
            if (!m_vc[i] && vp_i < 0) vp_i = i;
            if (m_vc[i] && m_clo[i] == vci[7:0] && vci[15:8] == 8'h00 && vc_i < 0) vc_i = i;
         end
      end
      act = 2; port = 2'd0; ovpi = vpi; ovci = vci; req = "R9";
      if (m_ben && vpi == m_bvpi) begin
         act = 1; req = "R6";
      end else if (vpi[11:4] != m_rng) begin
         act = 2; req = "R5";
      end else if ((vci == 16'd3 || vci == 16'd4) && known) begin
         act = 1; req = "R7";
      end else if (vc_i >= 0) begin
         if (pti == 3'b100) begin
            act = 1; req = "R8";
         end else begin
            act = 0; port = m_port[vc_i]; ovpi = m_nvpi[vc_i]; ovci = m_nvci[vc_i];
            req = (vp_i >= 0) ? "R4" : "R2";
         end
      end else if (vp_i >= 0) begin
         act = 0; port = m_port[vp_i]; ovpi = m_nvpi[vp_i];
         req = (pti == 3'b100) ? "R8" : "R3";
      end
      req = {phase, req};
   endtask

   task automatic run_cell(input logic [11:0] vpi, input logic [15:0] vci, input logic [2:0] pti,
                           input logic clp, input logic [7:0] hec, input logic [7:0] pay);
      logic [7:0]  b [6];
      logic [7:0]  e [6];
      int          act;
      logic [1:0]  port;
      logic [11:0] ovpi;
      logic [15:0] ovci;
      string       req;
      b = '{vpi[11:4], {vpi[3:0], vci[15:12]}, vci[11:4], {vci[3:0], pti, clp}, hec, pay};
      model(vpi, vci, pti, act, port, ovpi, ovci, req);
      e = '{ovpi[11:4], {ovpi[3:0], ovci[15:12]}, ovci[11:4], {ovci[3:0], pti, clp}, hec, pay};
      if (act == 2) exp_cnt++;
      for (int t = 0; t <= 10; t++) begin
         @(negedge clk);
         if (t >= 4 && t <= 9) begin
            int k = t - 4;
            logic [15:0] got = {out_valid, out_sop, out_cpu, out_drop, out_port, 2'b00, out_data};
            logic [15:0] exp = {1'b1, k == 0, act == 1, act == 2, port, 2'b00, e[k]};
            check(got == exp, (k >= 4) ? "R1" : req, $sformatf("byte %0d", k),
                  32'(got), 32'(exp));
            if (k == 0)
               check(drop_count == CNT_W'(exp_cnt), "R10", "drop_count",
                     32'(drop_count), 32'(exp_cnt));
         end
         if (t == 10)
            check(out_valid == 1'b0, "R1", "idle after cell", 32'(out_valid), 32'd0);
         if (t < 6) begin
            in_valid = 1'b1; in_sop = (t == 0); in_data = b[t];
         end else begin
            in_valid = 1'b0; in_sop = 1'b0; in_data = 8'h00;
         end
      end
   endtask

   task automatic sweep(input logic [7:0] seed);
      logic [15:0] vcis [7] = '{16'h0000, 16'h0003, 16'h0004, 16'h0010,
                                16'h0040, 16'h0140, 16'h0041};
      logic [7:0] ups [2] = '{8'h05, 8'h06};
      for (int u = 0; u < 2; u++)
         for (int lo = 0; lo < 4; lo++)
            for (int c = 0; c < 7; c++)
               for (int p = 0; p < 2; p++)
                  run_cell({ups[u], 4'(lo)}, vcis[c], p ? 3'b100 : 3'b000, lo[0],
                           8'(seed + 8'(c)), 8'(seed ^ 8'(lo * 16 + c)));
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         m_val[i] = 1'b0; m_vc[i] = 1'b0; m_port[i] = '0; m_lo[i] = '0;
         m_clo[i] = '0; m_nvpi[i] = '0; m_nvci[i] = '0;
      end
      repeat (4) @(negedge clk);
      // R11: outputs quiet during and right after reset
      check(out_valid == 1'b0, "R11", "out_valid in reset", 32'(out_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R11", "out_valid after reset", 32'(out_valid), 32'd0);
      check(drop_count == '0, "R11", "drop_count after reset", 32'(drop_count), 32'd0);
      // R11: empty table, range 0, no broadcast -> dropped
      phase = "R11 ";
      run_cell(12'h000, 16'h0010, 3'b000, 1'b0, 8'h5A, 8'hC3);
      run_cell(12'h001, 16'h0003, 3'b000, 1'b0, 8'h11, 8'h22);
      phase = "";

      wr_regs(8'h05, 1'b1, 12'h063);
      wr_entry(0, 1, 0, 2'd1, 4'h1, 8'h00, 12'h123, 16'h0000);
      wr_entry(1, 1, 1, 2'd2, 4'h2, 8'h40, 12'hABC, 16'h1234);
      wr_entry(2, 1, 1, 2'd3, 4'h1, 8'h10, 12'h777, 16'h0055);
      wr_entry(3, 1, 1, 2'd0, 4'h2, 8'h40, 12'h999, 16'h8888);
      wr_entry(4, 1, 0, 2'd2, 4'h1, 8'h00, 12'h456, 16'h0000);
      wr_entry(5, 1, 0, 2'd3, 4'h3, 8'h00, 12'hFED, 16'h0000);
      sweep(8'h30);

      // R12: removing entry 1 exposes entry 3; broadcast moved inside the range
      phase = "R12 ";
      wr_entry(1, 0, 1, 2'd2, 4'h2, 8'h40, 12'hABC, 16'h1234);
      wr_entry(5, 1, 1, 2'd1, 4'h3, 8'h41, 12'h0F0, 16'hBEEF);
      wr_regs(8'h05, 1'b1, 12'h052);
      sweep(8'h90);
      phase = "";

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule